// File: doc/BRIEF.md
# Load Address Generation Stage

This block forms the effective address of a fixed-point load in one registered pipeline stage. Each cycle it may accept one operation. An operation carries a form code, an update flag, the base and target register indices, the base register value, the index register value and the raw 16-bit displacement field. One cycle later it presents the 64-bit address together with a valid strobe. The register file read and the memory access are done by neighbouring stages.

The block picks the offset by form. The displacement is sign-extended, and in two of the forms its low bits are first forced to zero, which scales it. For the indexed form the offset is the full index register value. A base index of zero reads as the constant zero unless the operation is an update. An update requests a write of the address back into the base register. The block also checks the register indices. It flags an illegal update and an illegal quadword target, and a flagged operation never writes back.

Top module: `ldagen_stage`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly one clock. While `rst_n` is low, `out_valid`, `out_wb_en` and `out_err` are 0.
- R2: In a non-update operation a base index of 0 selects a base of zero, whatever the value on `in_base_val`.
- R3: Form code 0 (D) gives address = base + sign-extended `in_disp[15:0]`.
- R4: Form code 1 (DS) gives address = base + sign-extended `{in_disp[15:2], 2'b00}`, so `in_disp[1:0]` has no effect on the address.
- R5: Form code 2 (DQ, quadword) gives address = base + sign-extended `{in_disp[15:4], 4'b0000}`, so `in_disp[3:0]` has no effect on the address.
- R6: Form code 3 (X) gives address = base + `in_index_val`. The sum wraps modulo 2^64 and no carry is produced.
- R7: An update (`in_update`=1 with form 0, 1 or 3) always adds to `in_base_val`. When legal, it sets `out_wb_en`=1 with `out_wb_idx` equal to the base index, and the write-back value is `out_ea`.
- R8: An update with base index 0, or with base index equal to target index, sets `out_err`=1 and `out_wb_en`=0. The address is still output.
- R9: A form 2 operation sets `out_err`=1 when the target index is odd or equals the base index, which includes both being 0. `in_update` is ignored for form 2, so it never writes back.
- R10: `out_wb_en` and `out_err` are 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_form | input | 2 | Form code: 0 D, 1 DS, 2 DQ, 3 X |
| in_update | input | 1 | Update variant requested |
| in_base_idx | input | 5 | Base register index |
| in_tgt_idx | input | 5 | Target register index (pair index for form 2) |
| in_base_val | input | 64 | Contents of the base register |
| in_index_val | input | 64 | Contents of the index register (form 3) |
| in_disp | input | 16 | Raw displacement field |
| out_valid | output | 1 | Result valid |
| out_ea | output | 64 | Effective address |
| out_wb_en | output | 1 | Write `out_ea` back into a register |
| out_wb_idx | output | 5 | Register to write back |
| out_err | output | 1 | Illegal operand combination |

## Verification
Every result is due on the clock edge that follows the edge that accepted the operation. That covers the address, the write-back request and index, and the error flag, with no other latency anywhere. The driver changes inputs on the falling edge and pushes the expected result into a queue. The monitor samples one time unit after each rising edge and pops one entry per valid output. An output with an empty queue fails, and so does an entry still queued at the end. On cycles without a valid output, the monitor confirms that the write-back and error flags are low.

// File: rtl/lagu_pkg.sv
package lagu_pkg;
  parameter int unsigned XLEN   = 64;
  parameter int unsigned IDX_W  = 5;
  parameter int unsigned DISP_W = 16;
  localparam int unsigned DS_ZB = 2;
  localparam int unsigned DQ_ZB = 4;

  typedef enum logic [1:0] {
    FORM_D  = 2'd0,
    FORM_DS = 2'd1,
    FORM_DQ = 2'd2,
    FORM_X  = 2'd3
  } form_e;

  // clear the zb lowest displacement bits, then sign-extend to XLEN
  function automatic logic [XLEN-1:0] sext_scaled(input logic [DISP_W-1:0] d,
                                                  input int unsigned zb);
    logic [DISP_W-1:0] m;
    m = d;
    for (int i = 0; i < DISP_W; i++) begin
      if (i < int'(zb)) m[i] = 1'b0;
    end
    return {{(XLEN-DISP_W){m[DISP_W-1]}}, m};
  endfunction

  function automatic logic [XLEN-1:0] wrap_add(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    return a + b;
  endfunction
endpackage

// File: rtl/lagu_offset.sv
module lagu_offset
  import lagu_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned DW = DISP_W
) (
  input  form_e         form,
  input  logic [DW-1:0] disp,
  input  logic [W-1:0]  index_val,
  output logic [W-1:0]  offset
);
  always_comb begin
    unique case (form)
      FORM_D:  offset = sext_scaled(disp, 0);
      FORM_DS: offset = sext_scaled(disp, DS_ZB);
      FORM_DQ: offset = sext_scaled(disp, DQ_ZB);
      default: offset = index_val;
    endcase
  end
endmodule

// File: rtl/lagu_legal.sv
module lagu_legal
  import lagu_pkg::*;
#(
  parameter int unsigned IW = IDX_W
) (
  input  form_e         form,
  input  logic          update,
  input  logic [IW-1:0] base_idx,
  input  logic [IW-1:0] tgt_idx,
  output logic          upd_eff,
  output logic          upd_bad,
  output logic          qw_bad
);
  logic base_zero;
  logic same_reg;

  assign base_zero = (base_idx == '0);
  assign same_reg  = (base_idx == tgt_idx);
  assign upd_eff   = update && (form != FORM_DQ);
  assign upd_bad   = upd_eff && (base_zero || same_reg);
  assign qw_bad    = (form == FORM_DQ) && (tgt_idx[0] || same_reg);
endmodule

// File: rtl/lagu_base.sv
module lagu_base
  import lagu_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned IW = IDX_W
) (
  input  logic          upd_eff,
  input  logic [IW-1:0] base_idx,
  input  logic [W-1:0]  base_val,
  output logic [W-1:0]  base
);
  assign base = (upd_eff || (base_idx != '0)) ? base_val : '0;
endmodule

// File: rtl/ldagen_stage.sv
module ldagen_stage
  import lagu_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned IW = IDX_W,
  parameter int unsigned DW = DISP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_form,
  input  logic          in_update,
  input  logic [IW-1:0] in_base_idx,
  input  logic [IW-1:0] in_tgt_idx,
  input  logic [W-1:0]  in_base_val,
  input  logic [W-1:0]  in_index_val,
  input  logic [DW-1:0] in_disp,
  output logic          out_valid,
  output logic [W-1:0]  out_ea,
  output logic          out_wb_en,
  output logic [IW-1:0] out_wb_idx,
  output logic          out_err
);
  form_e         form;
  logic          upd_eff, upd_bad, qw_bad;
  logic          err_now, wb_now;
  logic [W-1:0]  base, offset, ea_now;

  assign form = form_e'(in_form);

  lagu_legal #(.IW(IW)) u_legal (
    .form(form), .update(in_update), .base_idx(in_base_idx),
    .tgt_idx(in_tgt_idx), .upd_eff(upd_eff), .upd_bad(upd_bad), .qw_bad(qw_bad)
  );

  lagu_base #(.W(W), .IW(IW)) u_base (
    .upd_eff(upd_eff), .base_idx(in_base_idx), .base_val(in_base_val), .base(base)
  );

  lagu_offset #(.W(W), .DW(DW)) u_off (
    .form(form), .disp(in_disp), .index_val(in_index_val), .offset(offset)
  );

  assign ea_now  = wrap_add(base, offset);
  assign err_now = upd_bad || qw_bad;
  assign wb_now  = upd_eff && !err_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_wb_en  <= 1'b0;
      out_err    <= 1'b0;
      out_ea     <= '0;
      out_wb_idx <= '0;
    end else begin
      out_valid <= in_valid;
      out_wb_en <= in_valid && wb_now;
      out_err   <= in_valid && err_now;
      if (in_valid) begin
        out_ea     <= ea_now;
        out_wb_idx <= in_base_idx;
      end
    end
  end

  // R1: one-cycle latency on the valid strobe
  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8: a flagged operation never writes back
  assert_err_blocks_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> !out_wb_en);
  // R10: flags only with a valid result
  assert_flags_need_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_wb_en && !out_err));
  // R7: write-back targets the accepted base index
  assert_wb_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wb_now) |=> (out_wb_en && out_wb_idx == $past(in_base_idx)));
  // R9: quadword target never requests write-back
  assert_qw_no_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form == FORM_DQ) |=> !out_wb_en);
endmodule

// File: tb/sim_ldagen_stage.sv
`timescale 1ns/1ps
module sim_ldagen_stage;
  typedef struct {
    logic [63:0] ea;
    logic        wb;
    logic [4:0]  idx;
    logic        err;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_form = '0;
  logic        in_update = 1'b0;
  logic [4:0]  in_base_idx = '0, in_tgt_idx = '0;
  logic [63:0] in_base_val = '0, in_index_val = '0;
  logic [15:0] in_disp = '0;
  logic        out_valid, out_wb_en, out_err;
  logic [63:0] out_ea;
  logic [4:0]  out_wb_idx;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ldagen_stage u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_form(in_form),
    .in_update(in_update), .in_base_idx(in_base_idx), .in_tgt_idx(in_tgt_idx),
    .in_base_val(in_base_val), .in_index_val(in_index_val), .in_disp(in_disp),
    .out_valid(out_valid), .out_ea(out_ea), .out_wb_en(out_wb_en),
    .out_wb_idx(out_wb_idx), .out_err(out_err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] f, input logic upd, input logic [4:0] bi,
                       input logic [4:0] ti, input logic [63:0] bv, input logic [63:0] iv,
                       input logic [15:0] d, input string tag);
    exp_t e;
    logic [63:0] b, off;
    logic [15:0] m;
    logic ue;
    ue = upd && (f != 2'd2);
    b = (ue || bi != 5'd0) ? bv : 64'd0;
    case (f)
      2'd0: m = d;
      2'd1: m = d & 16'hFFFC;
      2'd2: m = d & 16'hFFF0;
      default: m = 16'h0;
    endcase
    off = (f == 2'd3) ? iv : {{48{m[15]}}, m};
    e.ea  = b + off;
    e.err = ue ? (bi == 5'd0 || bi == ti) : ((f == 2'd2) ? (ti[0] || ti == bi) : 1'b0);
    e.wb  = ue && !e.err;
    e.idx = bi;
    e.tag = tag;
    @(negedge clk);
    in_valid = 1'b1; in_form = f; in_update = upd; in_base_idx = bi; in_tgt_idx = ti;
    in_base_val = bv; in_index_val = iv; in_disp = d;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    in_base_val = 64'hDEAD_BEEF_0000_0001;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor
  initial begin
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(posedge clk); #1;
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1", "unexpected valid", 64'd1, 64'd0);
        end else begin
          e = q.pop_front();
          chk(out_ea == e.ea, e.tag, "ea", out_ea, e.ea);
          chk(out_err == e.err, e.tag, "err", 64'(out_err), 64'(e.err));
          chk(out_wb_en == e.wb, e.tag, "wb_en", 64'(out_wb_en), 64'(e.wb));
          if (e.wb) chk(out_wb_idx == e.idx, e.tag, "wb_idx", 64'(out_wb_idx), 64'(e.idx));
        end
      end else begin
        chk(!out_wb_en && !out_err, "R10", "flags while idle",
            64'({out_wb_en, out_err}), 64'd0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!out_valid && !out_wb_en && !out_err, "R1", "reset state",
        64'({out_valid, out_wb_en, out_err}), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    // R3: D form positive and negative displacement
    drive(2'd0, 0, 5'd4, 5'd7, 64'h0000_0000_0001_0000, 64'h0, 16'h0123, "R3");
    drive(2'd0, 0, 5'd4, 5'd7, 64'h0000_0000_0001_0000, 64'h0, 16'hFFF0, "R3");
    // R2: base index zero ignores base value
    drive(2'd0, 0, 5'd0, 5'd7, 64'h1234_5678_9ABC_DEF0, 64'h0, 16'h8000, "R2");
    drive(2'd3, 0, 5'd0, 5'd7, 64'h1111_1111_1111_1111, 64'h0000_0000_0000_4444, 16'h0, "R2");
    // R4: DS form, low two bits ignored
    drive(2'd1, 0, 5'd9, 5'd2, 64'h0000_0000_0000_1000, 64'h0, 16'h0107, "R4");
    drive(2'd1, 0, 5'd9, 5'd2, 64'h0000_0000_0000_1000, 64'h0, 16'hFFFB, "R4");
    // R5: DQ form, low four bits ignored
    drive(2'd2, 0, 5'd3, 5'd4, 64'h0000_0000_0000_2000, 64'h0, 16'h012F, "R5");
    drive(2'd2, 0, 5'd3, 5'd6, 64'h0000_0000_0000_2000, 64'h0, 16'hFF1F, "R5");
    idle(2);
    // R6: X form and wrap
    drive(2'd3, 0, 5'd8, 5'd1, 64'h0000_0000_0000_0100, 64'h0000_0001_0000_0000, 16'hFFFF, "R6");
    drive(2'd3, 0, 5'd8, 5'd1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0020, 16'h0, "R6");
    // R7: legal updates
    drive(2'd0, 1, 5'd5, 5'd6, 64'h0000_0000_0000_3000, 64'h0, 16'h0010, "R7");
    drive(2'd3, 1, 5'd12, 5'd13, 64'h0000_0000_0000_3000, 64'h0000_0000_0000_0008, 16'h0, "R7");
    drive(2'd1, 1, 5'd31, 5'd1, 64'h0000_0000_0000_0040, 64'h0, 16'hFFFC, "R7");
    // R8: illegal updates, address still uses the base contents
    drive(2'd0, 1, 5'd0, 5'd6, 64'h0000_0000_0000_5000, 64'h0, 16'h0004, "R8");
    drive(2'd3, 1, 5'd7, 5'd7, 64'h0000_0000_0000_5000, 64'h0000_0000_0000_0001, 16'h0, "R8");
    // R9: quadword illegal targets and ignored update
    drive(2'd2, 0, 5'd2, 5'd5, 64'h0000_0000_0000_6000, 64'h0, 16'h0010, "R9");
    drive(2'd2, 0, 5'd0, 5'd0, 64'h0000_0000_0000_6000, 64'h0, 16'h0010, "R9");
    drive(2'd2, 0, 5'd8, 5'd8, 64'h0000_0000_0000_6000, 64'h0, 16'h0010, "R9");
    drive(2'd2, 1, 5'd3, 5'd10, 64'h0000_0000_0000_6000, 64'h0, 16'h0020, "R9");
    idle(4);
    chk(q.size() == 0, "R1", "pending results", 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule